// File: doc/BRIEF.md
# CAN Error Counter and Status Tracker

This block holds the fault-confinement state of a CAN controller. A protocol engine feeds it one-cycle pulses per frame: a transmit completed, a receive completed, or an error detected, the error carrying a 3-bit type code and a flag saying whether the node was transmitting. From these pulses the block keeps a transmit error count and a receive error count. It derives the warning, error-passive and bus-off conditions from them and records the type of the most recent bus event.

A CPU sees two 16-bit registers through a plain read/write port with a combinational read path. Address 0 is the status word and address 1 is the error-count word. A level request line tells the CPU that the confinement state moved or that a new error code was captured. The line stays high until the status word is read. Leaving bus-off is reduced to a single clear input, driven by whatever recovery logic sits beside the block.

Top module: `can_err_tracker`

## Requirements
- R1: After synchronous reset the status word reads 0x0007 (error-code field 7, all flags and success bits 0), the error-count word reads 0x0000 and `stat_irq` is 0.
- R2: At most one event is taken per cycle. An error pulse with code 1..6 wins over success pulses in the same cycle, and a transmit success wins over a receive success. An error pulse with code 0 or 7 is ignored, and any success pulse in that cycle is then taken as if the error pulse were absent.
- R3: A transmit success lowers the transmit count by 1 and a receive success lowers the receive count by 1, neither going below 0. Each sets its own status bit (transmit at bit 3, receive at bit 4) and writes 0 into the error-code field.
- R4: A receive-role error raises the receive count by 1, holding at 128. Any accepted error writes its code into status bits 2:0 (1 stuff, 2 form, 3 acknowledge, 4 bit1, 5 bit0, 6 CRC).
- R5: A transmit-role error raises the transmit count by 8.
- R6: A transmit-role error that would push the transmit count past 255 sets bus-off (status bit 7) and pins the count at 255. While bus-off holds, every event pulse is ignored.
- R7: `recov_clr` zeroes both counts and clears bus-off in the next cycle. Events in that same cycle are ignored.
- R8: Status bit 6 (warning) is 1 exactly when either count is 96 or more. Status bit 5 (passive) is 1 exactly when either count is above 127.
- R9: The error-count word carries the transmit count in bits 7:0 and the receive count in bits 14:8, shown as 127 once the count is above 127. Bit 15 is 1 exactly when the receive count is above 127.
- R10: A CPU write to address 0 loads bits 2:0 into the error-code field. For bits 3 and 4, a 0 clears the bit and a 1 leaves it unchanged. Bits 7:5 cannot be written. An event in the same cycle takes precedence over the write. Writes to address 1 have no effect.
- R11: `stat_irq` is set when bus-off, warning or passive changes value, or when an error is accepted. It clears on a read of address 0 (`cpu_rd` with `cpu_addr`=0) and is kept if a set happens in the same cycle. A read of address 1 does not clear it.
- R12: A 7 written into the error-code field remains until the next accepted event, so an unchanged 7 means no bus event since the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_ok | input | 1 | Transmit success pulse |
| ev_rx_ok | input | 1 | Receive success pulse |
| ev_err | input | 1 | Error detected pulse |
| ev_err_code | input | 3 | Error type code for ev_err |
| ev_err_is_tx | input | 1 | 1: node was transmitting when the error occurred |
| recov_clr | input | 1 | Bus-off recovery clear |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (clears request on address 0) |
| cpu_addr | input | 1 | 0 status word, 1 error-count word |
| cpu_wdata | input | 5 | Writable status bits 4:0 |
| cpu_rdata | output | 16 | Read data for cpu_addr |
| stat_irq | output | 1 | Status interrupt request |

## Verification
The hardest state to reach from the ports is bus-off: 32 transmit-role errors must arrive with few enough transmit successes between them, and the stimulus must then keep feeding events so that the block can be seen ignoring them. The random stimulus switches among traffic modes every few hundred cycles. One mode is a dense burst of transmit faults and another is receive-heavy with faults, which drives the receive count to its ceiling of 128. Recovery pulses are rare, so both the saturated states and the way out of them get visited. Directed sequences also cover the same-cycle precedence corners, the held error code 7 and bus-off entry.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    localparam int CNT_W    = 8;
    localparam int STAT_W   = 8;
    localparam int WORD_W   = 16;
    localparam int WR_W     = 5;

    typedef enum logic [2:0] {
        LEC_NONE   = 3'd0,
        LEC_STUFF  = 3'd1,
        LEC_FORM   = 3'd2,
        LEC_ACK    = 3'd3,
        LEC_BIT1   = 3'd4,
        LEC_BIT0   = 3'd5,
        LEC_CRC    = 3'd6,
        LEC_NOUPD  = 3'd7
    } lec_e;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_TX_DONE,
        EV_RX_DONE,
        EV_TX_FAULT,
        EV_RX_FAULT
    } evt_e;

    typedef struct packed {
        logic boff;
        logic warn;
        logic pasv;
    } flags_t;

    function automatic logic code_valid(input logic [2:0] code);
        return (code != 3'(LEC_NONE)) && (code != 3'(LEC_NOUPD));
    endfunction

    // Single event per cycle: accepted fault, then transmit, then receive.
    function automatic evt_e classify(
        input logic       err,
        input logic [2:0] code,
        input logic       is_tx,
        input logic       tx_ok,
        input logic       rx_ok,
        input logic       blocked
    );
        evt_e e;
        if (blocked)                 e = EV_IDLE;
        else if (err && code_valid(code))
                                     e = is_tx ? EV_TX_FAULT : EV_RX_FAULT;
        else if (tx_ok)              e = EV_TX_DONE;
        else if (rx_ok)              e = EV_RX_DONE;
        else                         e = EV_IDLE;
        return e;
    endfunction

    function automatic flags_t derive_flags(
        input logic [CNT_W-1:0] tec,
        input logic [CNT_W-1:0] rec,
        input logic             boff,
        input int               warn_lvl,
        input int               pasv_lvl
    );
        flags_t f;
        f.boff = boff;
        f.warn = (int'(tec) >= warn_lvl) || (int'(rec) >= warn_lvl);
        f.pasv = (int'(tec) >  pasv_lvl) || (int'(rec) >  pasv_lvl);
        return f;
    endfunction

endpackage

// File: rtl/can_err_counters.sv
module can_err_counters
    import can_err_pkg::*;
#(
    parameter int TX_PENALTY = 8,
    parameter int REC_CEIL   = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             recov_clr,
    input  evt_e             evt,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             boff,
    output logic [CNT_W-1:0] tec_n,
    output logic [CNT_W-1:0] rec_n,
    output logic             boff_n
);

    localparam logic [CNT_W-1:0] TEC_MAX  = '1;
    localparam logic [CNT_W-1:0] STEP     = CNT_W'(TX_PENALTY);
    localparam logic [CNT_W-1:0] TEC_LIM  = TEC_MAX - STEP;
    localparam logic [CNT_W-1:0] REC_TOP  = CNT_W'(REC_CEIL);

    always_comb begin
        tec_n  = tec;
        rec_n  = rec;
        boff_n = boff;
        if (recov_clr) begin
            tec_n  = '0;
            rec_n  = '0;
            boff_n = 1'b0;
        end else begin
            case (evt)
                EV_TX_FAULT: begin
                    if (tec > TEC_LIM) begin
                        tec_n  = TEC_MAX;
                        boff_n = 1'b1;
                    end else begin
                        tec_n = tec + STEP;
                    end
                end
                EV_RX_FAULT: if (rec < REC_TOP) rec_n = rec + 1'b1;
                EV_TX_DONE:  if (tec != '0)     tec_n = tec - 1'b1;
                EV_RX_DONE:  if (rec != '0)     rec_n = rec - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tec  <= '0;
            rec  <= '0;
            boff <= 1'b0;
        end else begin
            tec  <= tec_n;
            rec  <= rec_n;
            boff <= boff_n;
        end
    end

endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import can_err_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  evt_e            evt,
    input  logic [2:0]      code,
    input  logic            wr_stat,
    input  logic [WR_W-1:0] wdata,
    input  logic            rd_stat,
    input  logic            flag_chg,
    output logic            txok,
    output logic            rxok,
    output lec_e            lec,
    output logic            irq
);

    logic fault;
    logic irq_set;

    assign fault   = (evt == EV_TX_FAULT) || (evt == EV_RX_FAULT);
    assign irq_set = fault || flag_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            txok <= 1'b0;
            rxok <= 1'b0;
            lec  <= LEC_NOUPD;
            irq  <= 1'b0;
        end else begin
            // hardware update takes precedence over a CPU write
            if (fault)
                lec <= lec_e'(code);
            else if (evt == EV_TX_DONE || evt == EV_RX_DONE)
                lec <= LEC_NONE;
            else if (wr_stat)
                lec <= lec_e'(wdata[2:0]);

            if (evt == EV_TX_DONE)          txok <= 1'b1;
            else if (wr_stat && !wdata[3])  txok <= 1'b0;

            if (evt == EV_RX_DONE)          rxok <= 1'b1;
            else if (wr_stat && !wdata[4])  rxok <= 1'b0;

            if (irq_set)       irq <= 1'b1;
            else if (rd_stat)  irq <= 1'b0;
        end
    end

endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
    import can_err_pkg::*;
#(
    parameter int WARN_LEVEL = 96,
    parameter int PASV_LEVEL = 127,
    parameter int TX_PENALTY = 8,
    parameter int REC_CEIL   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              ev_err,
    input  logic [2:0]        ev_err_code,
    input  logic              ev_err_is_tx,
    input  logic              recov_clr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_addr,
    input  logic [WR_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              stat_irq
);

    localparam int DISP_W = CNT_W - 1;

    logic [CNT_W-1:0] tec, rec, tec_n, rec_n;
    logic             bus_off, bus_off_n;
    logic             txok, rxok;
    lec_e             lec;
    evt_e             evt;
    flags_t           flg_now, flg_nxt;
    logic             rx_pasv;
    logic [DISP_W-1:0] rec_disp;
    logic [STAT_W-1:0] stat_byte;

    assign evt = classify(ev_err, ev_err_code, ev_err_is_tx,
                          ev_tx_ok, ev_rx_ok, bus_off || recov_clr);

    can_err_counters #(
        .TX_PENALTY (TX_PENALTY),
        .REC_CEIL   (REC_CEIL)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .recov_clr (recov_clr),
        .evt       (evt),
        .tec       (tec),
        .rec       (rec),
        .boff      (bus_off),
        .tec_n     (tec_n),
        .rec_n     (rec_n),
        .boff_n    (bus_off_n)
    );

    assign flg_now = derive_flags(tec,   rec,   bus_off,   WARN_LEVEL, PASV_LEVEL);
    assign flg_nxt = derive_flags(tec_n, rec_n, bus_off_n, WARN_LEVEL, PASV_LEVEL);

    can_err_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .code     (ev_err_code),
        .wr_stat  (cpu_wr && !cpu_addr),
        .wdata    (cpu_wdata),
        .rd_stat  (cpu_rd && !cpu_addr),
        .flag_chg (flg_now != flg_nxt),
        .txok     (txok),
        .rxok     (rxok),
        .lec      (lec),
        .irq      (stat_irq)
    );

    assign rx_pasv   = int'(rec) > PASV_LEVEL;
    assign rec_disp  = rx_pasv ? '1 : rec[DISP_W-1:0];
    assign stat_byte = {flg_now.boff, flg_now.warn, flg_now.pasv, rxok, txok, lec};
    assign cpu_rdata = cpu_addr ? {rx_pasv, rec_disp, tec}
                                : {{(WORD_W-STAT_W){1'b0}}, stat_byte};

endmodule

// File: rtl/can_err_tracker_chk.sv
module can_err_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_err,
    input logic [2:0] ev_err_code,
    input logic       ev_err_is_tx,
    input logic       recov_clr,
    input logic [7:0] tec,
    input logic [7:0] rec,
    input logic       bus_off,
    input logic       stat_irq
);

    logic fault_ok;
    assign fault_ok = ev_err && (ev_err_code != 3'd0) && (ev_err_code != 3'd7)
                      && !bus_off && !recov_clr;

    // R5: transmit fault below the limit adds exactly eight
    a_r5_tx_step: assert property (@(posedge clk) disable iff (rst)
        (fault_ok && ev_err_is_tx && tec < 8'd248) |=> (tec == $past(tec) + 8'd8));

    // R6: bus-off pins the transmit count
    a_r6_boff_pinned: assert property (@(posedge clk) disable iff (rst)
        bus_off |-> (tec == 8'hFF));

    // R6: bus-off holds until a recovery clear
    a_r6_boff_sticky: assert property (@(posedge clk) disable iff (rst)
        (bus_off && !recov_clr) |=> bus_off);

    // R7: recovery clear empties both counts
    a_r7_recover: assert property (@(posedge clk) disable iff (rst)
        recov_clr |=> (tec == 8'd0 && rec == 8'd0 && !bus_off));

    // R4: receive count ceiling
    a_r4_rec_ceiling: assert property (@(posedge clk) disable iff (rst)
        rec <= 8'd128);

    // R11: an accepted fault raises the request
    a_r11_fault_irq: assert property (@(posedge clk) disable iff (rst)
        fault_ok |=> stat_irq);

endmodule

bind can_err_tracker can_err_tracker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_err       (ev_err),
    .ev_err_code  (ev_err_code),
    .ev_err_is_tx (ev_err_is_tx),
    .recov_clr    (recov_clr),
    .tec          (tec),
    .rec          (rec),
    .bus_off      (bus_off),
    .stat_irq     (stat_irq)
);

// File: tb/tb_can_err_tracker.sv
`timescale 1ns/100ps
module tb_can_err_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_err = 0, ev_err_is_tx = 0;
    logic [2:0]  ev_err_code = 0;
    logic        recov_clr = 0, cpu_wr = 0, cpu_rd = 0, cpu_addr = 0;
    logic [4:0]  cpu_wdata = 0;
    logic [15:0] cpu_rdata;
    logic        stat_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    int m_tec, m_rec, m_lec;
    bit m_boff, m_txok, m_rxok, m_irq;

    always #2 clk = ~clk;

    can_err_tracker dut (
        .clk(clk), .rst(rst), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_err(ev_err), .ev_err_code(ev_err_code), .ev_err_is_tx(ev_err_is_tx),
        .recov_clr(recov_clr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .stat_irq(stat_irq)
    );

    task automatic check_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit f_warn(int t, int r); return (t >= 96) || (r >= 96); endfunction
    function automatic bit f_pasv(int t, int r); return (t > 127) || (r > 127); endfunction

    task automatic model_step(bit tx, bit rx, bit er, int code, bit istx,
                              bit rc, bit wr, bit rd, bit ad, int wd);
        int kind; // 0 none 1 txdone 2 rxdone 3 txfault 4 rxfault
        bit ow, op, ob, setirq;
        ow = f_warn(m_tec, m_rec); op = f_pasv(m_tec, m_rec); ob = m_boff;
        kind = 0;
        if (!rc && !m_boff) begin
            if (er && code >= 1 && code <= 6) kind = istx ? 3 : 4;
            else if (tx) kind = 1;
            else if (rx) kind = 2;
        end
        if (rc) begin m_tec = 0; m_rec = 0; m_boff = 0; end
        case (kind)
            1: if (m_tec > 0) m_tec--;
            2: if (m_rec > 0) m_rec--;
            3: if (m_tec + 8 > 255) begin m_tec = 255; m_boff = 1; end else m_tec += 8;
            4: if (m_rec < 128) m_rec++;
            default: ;
        endcase
        if (kind >= 3) m_lec = code;
        else if (kind != 0) m_lec = 0;
        else if (wr && !ad) m_lec = wd & 7;
        if (kind == 1) m_txok = 1; else if (wr && !ad && !wd[3]) m_txok = 0;
        if (kind == 2) m_rxok = 1; else if (wr && !ad && !wd[4]) m_rxok = 0;
        setirq = (kind >= 3) || (ow != f_warn(m_tec, m_rec)) ||
                 (op != f_pasv(m_tec, m_rec)) || (ob != m_boff);
        if (setirq) m_irq = 1; else if (rd && !ad) m_irq = 0;
    endtask

    task automatic read_regs(output logic [15:0] st, output logic [15:0] ec);
        cpu_rd = 0;
        cpu_addr = 0; #0.5; st = cpu_rdata;
        cpu_addr = 1; #0.5; ec = cpu_rdata;
    endtask

    task automatic compare_all();
        logic [15:0] st, ec;
        read_regs(st, ec);
        check_eq("R3",  "ok bits",   int'(st[4:3]), {m_rxok, m_txok});
        check_eq("R12", "lec",       int'(st[2:0]), m_lec);
        check_eq("R8",  "warn/pasv", int'(st[6:5]), {f_warn(m_tec, m_rec), f_pasv(m_tec, m_rec)});
        check_eq("R6",  "bus-off",   int'(st[7]),   m_boff);
        check_eq("R5",  "tec",       int'(ec[7:0]), m_tec);
        check_eq("R4",  "rec field", int'(ec[14:8]), (m_rec > 127) ? 127 : m_rec);
        check_eq("R9",  "rx passive", int'(ec[15]), m_rec > 127);
        check_eq("R11", "irq",       int'(stat_irq), m_irq);
    endtask

    task automatic drive(bit tx, bit rx, bit er, int code, bit istx,
                         bit rc, bit wr, bit rd, bit ad, int wd);
        ev_tx_ok = tx; ev_rx_ok = rx; ev_err = er; ev_err_code = 3'(code);
        ev_err_is_tx = istx; recov_clr = rc; cpu_wr = wr; cpu_rd = rd;
        cpu_addr = ad; cpu_wdata = 5'(wd);
        @(posedge clk);
        model_step(tx, rx, er, code, istx, rc, wr, rd, ad, wd);
        #1;
        ev_tx_ok = 0; ev_rx_ok = 0; ev_err = 0; recov_clr = 0;
        cpu_wr = 0; cpu_rd = 0;
        compare_all();
    endtask

    task automatic idle(); drive(0,0,0,0,0,0,0,0,0,0); endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, ec;
        int mode;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        m_tec = 0; m_rec = 0; m_lec = 7; m_boff = 0; m_txok = 0; m_rxok = 0; m_irq = 0;
        // R1 reset values
        read_regs(st, ec);
        check_eq("R1", "status", int'(st), 16'h0007);
        check_eq("R1", "errcnt", int'(ec), 0);
        check_eq("R1", "irq",    int'(stat_irq), 0);

        // R12: no event, code 7 held
        idle(); idle();
        // R2: error with code 0 and 7 ignored, success taken instead
        drive(1,0,1,0,1,0,0,0,0,0);
        read_regs(st, ec);
        check_eq("R2", "code0 tec", int'(ec[7:0]), 0);
        check_eq("R2", "code0 txok", int'(st[3]), 1);
        drive(0,1,1,7,0,0,0,0,0,0);
        read_regs(st, ec);
        check_eq("R2", "code7 rec", int'(ec[14:8]), 0);
        check_eq("R2", "code7 rxok", int'(st[4]), 1);
        // R2: valid fault beats success pulses
        drive(1,1,1,2,0,0,0,0,0,0);
        read_regs(st, ec);
        check_eq("R2", "fault wins rec", int'(ec[14:8]), 1);
        check_eq("R2", "fault lec", int'(st[2:0]), 2);
        // R10: write 0 clears ok bits, write 7 to lec, flags unwritable
        drive(0,0,0,0,0,0,1,0,0,5'b00111);
        read_regs(st, ec);
        check_eq("R10", "ok cleared", int'(st[4:3]), 0);
        // R12: 7 persists across idle cycles
        repeat (4) idle();
        read_regs(st, ec);
        check_eq("R12", "lec held 7", int'(st[2:0]), 7);
        // R10: write to errcnt address ignored
        drive(0,0,0,0,0,0,1,0,1,5'b11111);
        read_regs(st, ec);
        check_eq("R10", "errcnt write ignored", int'(ec), 16'h0100);
        // R11: read of errcnt keeps irq, read of status clears
        drive(0,0,0,0,0,0,0,1,1,0);
        check_eq("R11", "errcnt read keeps", int'(stat_irq), 1);
        drive(0,0,0,0,0,0,0,1,0,0);
        check_eq("R11", "status read clears", int'(stat_irq), 0);
        // R6: drive to bus-off, then events ignored
        repeat (33) drive(0,0,1,4,1,0,0,0,0,0);
        read_regs(st, ec);
        check_eq("R6", "bus-off set", int'(st[7]), 1);
        check_eq("R6", "tec pinned", int'(ec[7:0]), 255);
        drive(1,1,0,0,0,0,0,0,0,0);
        read_regs(st, ec);
        check_eq("R6", "ignored in bus-off", int'(ec[7:0]), 255);
        // R7: recovery clear, simultaneous fault ignored
        drive(0,0,1,3,0,1,0,0,0,0);
        read_regs(st, ec);
        check_eq("R7", "counts cleared", int'(ec), 0);
        check_eq("R7", "bus-off cleared", int'(st[7]), 0);

        // constrained random traffic
        mode = 0;
        for (int i = 0; i < 6000; i++) begin
            bit tx, rx, er, istx, rc, wr, rd, ad;
            int code, wd, r;
            if (i % 250 == 0) mode = $urandom_range(0, 3);
            r = $urandom_range(0, 99);
            tx = 0; rx = 0; er = 0; istx = 0;
            code = $urandom_range(0, 7);
            case (mode)
                0: begin tx = r < 30; rx = r >= 30 && r < 60; er = r >= 90; istx = $urandom_range(0,1); end
                1: begin er = r < 55; istx = 1; tx = r >= 55 && r < 65; code = $urandom_range(1,6); end
                2: begin er = r < 50; istx = 0; rx = r >= 50 && r < 60; code = $urandom_range(1,6); end
                default: begin tx = $urandom_range(0,1); rx = $urandom_range(0,1);
                               er = $urandom_range(0,1); istx = $urandom_range(0,1); end
            endcase
            rc = ($urandom_range(0, 399) == 0);
            wr = ($urandom_range(0, 9) == 0);
            rd = ($urandom_range(0, 7) == 0);
            ad = $urandom_range(0, 1);
            wd = $urandom_range(0, 31);
            drive(tx, rx, er, code, istx, rc, wr, rd, ad, wd);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule